// File: doc/BRIEF.md
# Programmable Address Region Decoder

This block classifies every processor access against a bank of sixteen programmable region descriptors. Each descriptor is one 32-bit word. It holds a three-bit target code, three permission bits, a page-size select, an eleven-bit length in pages and a fourteen-bit start page. For the current access the decoder reports whether any enabled region covers the address, which region that is, its target code and its permission attributes. All of these outputs follow the access inputs in the same cycle.

A write that lands in a region whose writes are disabled is a write-protect violation. The violation sets a sticky status bit on the next clock edge. Software clears that bit by writing a one to it. An enable bit in a control word gates the status bit onto an interrupt output. All descriptors and both control words are loaded through a simple word-indexed write port. Chip-select generation and cache behaviour belong to other blocks.

Top module: `addr_region_decoder`

## Requirements
- R1: A write on the configuration port with index 0 to 15 replaces the whole descriptor of that region. The new descriptor affects decoding from the next cycle.
- R2: A region covers byte addresses from start·P up to, but not including, (start + size + 1)·P. Start is bits 13:0 and size is bits 24:14. P is 65536 when bit 25 is set and 4096 when it is clear.
- R3: When several enabled regions cover the address, the one with the lowest index is reported.
- R4: A descriptor whose bits 31:29 are zero is disabled and never matches.
- R5: An address at or above 0x40000000 never produces a hit.
- R6: On a hit the outputs give the region index and the target from bits 31:29. They also give the no-execute flag from bit 28, the no-cache flag from bit 27 and the no-write flag from bit 26. Without a hit, or while acc_valid is low, all of these outputs are zero.
- R7: A valid write access that hits a region with bit 26 set sets the violation status on the next edge. Reads never set it, and neither do writes to other regions.
- R8: The violation status stays set until a configuration write to index 17 with data bit 0 equal to one. A new violation in the same cycle as that clear keeps the status set.
- R9: Bit 7 of the control word at configuration index 16 enables the interrupt. irq is high exactly when the status and that enable are both set.
- R10: After reset all descriptors, the enable and the status are zero, so there is no hit and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Word index: 0-15 descriptors, 16 control, 17 status |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | Access is a write |
| hit | output | 1 | An enabled region covers the access |
| region | output | 4 | Index of the winning region |
| target | output | 3 | Target code of the winning region |
| no_exec | output | 1 | Winning region forbids execution |
| no_cache | output | 1 | Winning region forbids caching |
| no_write | output | 1 | Winning region forbids writes |
| wpv_status | output | 1 | Sticky write-protect violation flag |
| irq | output | 1 | Violation interrupt |

## Verification
The assertions assume that the access inputs are stable and known at every clock edge while reset is released. They also assume that a configuration write and a status clear are presented as single-cycle strobes. The bench drives all inputs at the falling edge, so this always holds, and it keeps them at zero while reset is asserted. Addresses are chosen so that they land on region boundaries, on overlapping regions, on disabled descriptors and just above the addressable limit. The configuration traffic mixes status clears that collide with violations, enable toggles and occasional random descriptor rewrites.

// File: rtl/addr_region_decoder.sv
module addr_region_decoder #(
  parameter int          NREG     = 16,
  parameter int          CFG_AW   = 5,
  parameter int          PG_SMALL = 12,
  parameter int          PG_BIG   = 16,
  parameter logic [31:0] LIMIT    = 32'h4000_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [31:0]             cfg_wdata,
  input  logic                    acc_valid,
  input  logic [31:0]             acc_addr,
  input  logic                    acc_write,
  output logic                    hit,
  output logic [$clog2(NREG)-1:0] region,
  output logic [2:0]              target,
  output logic                    no_exec,
  output logic                    no_cache,
  output logic                    no_write,
  output logic                    wpv_status,
  output logic                    irq
);
  localparam int RW = $clog2(NREG);
  localparam logic [CFG_AW-1:0] CTRL_A = CFG_AW'(NREG);
  localparam logic [CFG_AW-1:0] STAT_A = CFG_AW'(NREG + 1);

  logic [31:0] desc [NREG];
  logic [32:0] lo   [NREG];
  logic [32:0] span [NREG];
  logic [NREG-1:0] match;
  logic [RW-1:0] sel;
  logic found, irq_en;
  logic [32:0] a33;

  assign a33 = {1'b0, acc_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) desc[k] <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < NREG; k++)
        if (cfg_addr == CFG_AW'(k)) desc[k] <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_rgn
    assign lo[i]    = {19'b0, desc[i][13:0]} << (desc[i][25] ? PG_BIG : PG_SMALL);
    assign span[i]  = {21'b0, {1'b0, desc[i][24:14]} + 12'd1} << (desc[i][25] ? PG_BIG : PG_SMALL);
    assign match[i] = (desc[i][31:29] != 3'b000) && (acc_addr < LIMIT)
                      && (a33 >= lo[i]) && (a33 < lo[i] + span[i]);
  end

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int k = NREG - 1; k >= 0; k--)
      if (match[k]) begin
        sel   = RW'(k);
        found = 1'b1;
      end
  end

  assign hit      = acc_valid && found;
  assign region   = hit ? sel : '0;
  assign target   = hit ? desc[sel][31:29] : 3'b000;
  assign no_exec  = hit && desc[sel][28];
  assign no_cache = hit && desc[sel][27];
  assign no_write = hit && desc[sel][26];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpv_status <= 1'b0;
      irq_en     <= 1'b0;
    end else begin
      if (acc_write && no_write)
        wpv_status <= 1'b1;
      else if (cfg_we && cfg_addr == STAT_A && cfg_wdata[0])
        wpv_status <= 1'b0;
      if (cfg_we && cfg_addr == CTRL_A)
        irq_en <= cfg_wdata[7];
    end
  end

  assign irq = wpv_status && irq_en;

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (target == 3'b000 && !no_exec && !no_cache && !no_write)); // R6
  AST_HIGH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr >= LIMIT) |-> !hit); // R5
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (target != 3'b000)); // R4
  AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wpv_status) |-> $past(acc_valid && acc_write && no_write)); // R7
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wpv_status) |-> $past(cfg_we && cfg_addr == STAT_A && cfg_wdata[0])); // R8
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wpv_status); // R9
endmodule

// File: tb/addr_region_decoder_bench.sv
`timescale 1ns/1ps
module addr_region_decoder_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, acc_valid = 0, acc_write = 0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, acc_addr = '0;
  logic hit, no_exec, no_cache, no_write, wpv_status, irq;
  logic [3:0] region;
  logic [2:0] target;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_desc [16];
  bit m_st, m_en;

  always #4 clk = ~clk;

  addr_region_decoder u_addr_region_decoder (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .acc_valid, .acc_addr,
    .acc_write, .hit, .region, .target, .no_exec, .no_cache, .no_write,
    .wpv_status, .irq);

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void mdl(input logic [31:0] a, input logic v,
      output bit h, output int r, output int t, output bit ne, nc, nw);
    h = 0; r = 0; t = 0; ne = 0; nc = 0; nw = 0;
    if (!v || a >= 32'h4000_0000) return;
    for (int k = 0; k < 16; k++) begin
      longint ps, lo_b, hi_b;
      if (m_desc[k][31:29] == 0) continue;
      ps   = m_desc[k][25] ? 65536 : 4096;
      lo_b = longint'(m_desc[k][13:0]) * ps;
      hi_b = lo_b + (longint'(m_desc[k][24:14]) + 1) * ps;
      if (longint'(a) >= lo_b && longint'(a) < hi_b) begin
        h = 1; r = k; t = m_desc[k][31:29];
        ne = m_desc[k][28]; nc = m_desc[k][27]; nw = m_desc[k][26];
        return;
      end
    end
  endfunction

  task automatic cyc(input bit we, input int ca, input logic [31:0] wd,
                     input bit v, input logic [31:0] a, input bit w);
    bit h, ne, nc, nw;
    int r, t;
    @(negedge clk);
    cfg_we = we; cfg_addr = 5'(ca); cfg_wdata = wd;
    acc_valid = v; acc_addr = a; acc_write = w;
    #1;
    mdl(a, v, h, r, t, ne, nc, nw);
    chk("R2 hit", hit, h);
    chk("R3 region", region, r);
    chk("R6 target", target, t);
    chk("R6 attrs", {no_exec, no_cache, no_write}, {ne, nc, nw});
    chk("R7 status", wpv_status, m_st);
    chk("R9 irq", irq, m_st & m_en);
    if (v && w && h && nw) m_st = 1;
    else if (we && ca == 17 && wd[0]) m_st = 0;
    if (we && ca < 16) m_desc[ca] = wd;
    if (we && ca == 16) m_en = wd[7];
  endtask

  task automatic rd(input logic [31:0] a);
    cyc(0, 0, 0, 1, a, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) m_desc[k] = '0;
    m_st = 0; m_en = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 hit in reset", hit, 0);
    chk("R10 status in reset", wpv_status, 0);
    chk("R10 irq in reset", irq, 0);
    @(negedge clk);
    rst_n = 1;
    rd(32'h0010_0000);
    chk("R10 no hit after reset", hit, 0);

    cyc(1, 3,  32'h4400_C100, 0, 0, 0);
    cyc(1, 5,  32'h7003_C0F8, 0, 0, 0);
    cyc(1, 6,  32'h0200_2000, 0, 0, 0);
    cyc(1, 7,  32'h8A07_FFFF, 0, 0, 0);
    cyc(1, 8,  32'hE3FF_C000, 0, 0, 0);
    cyc(1, 9,  32'hE3FF_C800, 0, 0, 0);
    cyc(1, 10, 32'h2200_2000, 0, 0, 0);

    rd(32'h0010_0000);
    chk("R3 overlap lowest wins", region, 3);
    chk("R1 R6 target of region 3", target, 2);
    chk("R6 no_write of region 3", no_write, 1);
    rd(32'h0010_3FFF); chk("R2 last byte of 4K region", region, 3);
    rd(32'h0010_4000); chk("R2 first byte past 4K region", region, 5);
    rd(32'h000F_8000); chk("R6 no_exec of region 5", no_exec, 1);
    rd(32'h07FF_FFFF); chk("R2 end of 64K region", region, 8);
    rd(32'h0800_0000); chk("R2 second SDRAM region", region, 9);
    chk("R6 SDRAM target", target, 7);
    rd(32'h1000_0000); chk("R2 beyond all regions", hit, 0);
    rd(32'h2000_0000); chk("R4 disabled region skipped", region, 10);
    rd(32'h3FFF_FFFC); chk("R6 no_cache near limit", no_cache, 1);
    rd(32'h4000_0000); chk("R5 limit address misses", hit, 0);
    cyc(0, 0, 0, 0, 32'h0010_0000, 1);
    chk("R6 invalid access no hit", hit, 0);
    rd(32'h0010_0000);
    chk("R7 invalid write ignored", wpv_status, 0);
    rd(32'h0010_0000);
    chk("R7 read no violation", wpv_status, 0);
    cyc(0, 0, 0, 1, 32'h0800_0000, 1);
    rd(0);
    chk("R7 write to writable region", wpv_status, 0);
    cyc(0, 0, 0, 1, 32'h0010_0010, 1);
    rd(0);
    chk("R7 violation sets status", wpv_status, 1);
    chk("R9 irq masked", irq, 0);
    cyc(1, 16, 32'h0000_0080, 0, 0, 0);
    rd(0);
    chk("R9 irq enabled", irq, 1);
    cyc(1, 17, 32'h0000_0000, 0, 0, 0);
    rd(0);
    chk("R8 zero write keeps status", wpv_status, 1);
    cyc(1, 17, 32'h0000_0001, 1, 32'h0010_0000, 1);
    rd(0);
    chk("R8 set beats clear", wpv_status, 1);
    cyc(1, 17, 32'h0000_0001, 0, 0, 0);
    rd(0);
    chk("R8 clear", wpv_status, 0);
    chk("R9 irq drops", irq, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] base, a, wd;
      int sel, ca;
      bit we;
      sel = $urandom_range(0, 8);
      case (sel)
        0: base = 32'h000F_8000;
        1: base = 32'h0010_0000;
        2: base = 32'h0010_3F00;
        3: base = 32'h07FF_F000;
        4: base = 32'h0800_0000;
        5: base = 32'h2000_0000;
        6: base = 32'h3FFF_F000;
        7: base = 32'h4000_0000;
        default: base = $urandom;
      endcase
      a = base + 32'($urandom_range(0, 32'h1FFF));
      we = 0; ca = 0; wd = $urandom;
      case ($urandom_range(0, 31))
        0, 1, 2: begin we = 1; ca = 17; end
        3: begin we = 1; ca = 16; end
        4: begin we = 1; ca = $urandom_range(0, 15); end
        default: ;
      endcase
      cyc(we, ca, wd, 1'($urandom_range(0, 3) != 0), a, 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule